// File: doc/BRIEF.md
# Masked Interrupt Flag and Enable Unit

This block gathers five single-cycle event pulses and keeps a sticky pending flag for each one. It also keeps an enable mask of the same width, and it drives one active-low interrupt request line that goes low while any pending flag is also enabled. A host on a byte-wide register bus changes the mask with one write strobe. Data bit 7 of that write decides whether the selected bits are turned on or turned off. The host reads the flag word with one read strobe, and that read also empties the flags.

The read word carries the five flags in its low bits and a summary bit in bit 7. The summary bit is set whenever an enabled flag is pending. After every change to the flags or to the mask, the request is computed again, and the output register takes the new value at the same clock edge as the state that caused it. An event that arrives in the cycle of a clearing read is kept. Address decoding is left to the surrounding logic, and so are the event sources.

Top module: `irq_flag_mask_unit`

## Requirements
- R1: A synchronous active-low reset clears all flags and all mask bits. While reset is held and in the cycle after it, `irq_n` is 1 and `rd_data` is 0x00.
- R2: An event pulse on `evt_i[k]` sets flag k at the next rising edge. The flags are visible as `rd_data[4:0]`, where bit 0 is timer A underflow, bit 1 is timer B underflow, bit 2 is the clock alarm, bit 3 is the serial port and bit 4 is the external edge input. `rd_data[6:5]` always read 0.
- R3: At the edge of a mask write whose `wr_data[7]` is 1, every mask bit k that has `wr_data[k]` = 1 (for k in 4:0) becomes 1, and the other mask bits keep their value.
- R4: At the edge of a mask write whose `wr_data[7]` is 0, every mask bit k that has `wr_data[k]` = 1 becomes 0, and the other mask bits keep their value.
- R5: `rd_data[7]` is 1 exactly when some flag and its mask bit are both 1.
- R6: `irq_n` is registered. After any edge it equals the inverse of the new summary condition. An event whose mask bit is 0 sets its flag but leaves `irq_n` at 1.
- R7: Setting a mask bit for a flag that is already pending drives `irq_n` to 0 after the write edge, with no new event.
- R8: In a cycle with `rd_stb` = 1, `rd_data` shows the flags and the summary as they were before the edge. At that edge every flag clears and `irq_n` returns to 1, unless R9 applies.
- R9: An event pulse in the same cycle as a clearing read leaves its flag set after that edge. If that flag is enabled, `irq_n` stays 0.
- R10: Flags are sticky. Without a read, no flag clears, and a repeated event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 5 | Single-cycle event pulses, one per source |
| rd_stb | input | 1 | Read strobe for the flag word; clears the flags at the edge |
| wr_stb | input | 1 | Mask write strobe |
| wr_data | input | 8 | Write data: bit 7 selects set or clear, bits 4:0 select mask bits |
| rd_data | output | 8 | Flag word: summary in bit 7, flags in bits 4:0 |
| irq_n | output | 1 | Registered interrupt request, active low |

## Verification
A wrong flag bit shows in `rd_data[4:0]` in the very next cycle. It also shows in the summary bit and in `irq_n` as soon as that bit's mask bit is set. The mask cannot be read back, so a wrong mask bit shows only through `rd_data[7]` and `irq_n`. It stays hidden until its flag is pending, so the tests pair every mask change with a pending or a fresh event. The same-cycle read-and-event case is the one that would quietly lose an interrupt, so it is driven with the flag both enabled and disabled.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int unsigned SRC_N  = 5;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_BIT = DATA_W - 1;
  localparam int unsigned PAD_W  = DATA_W - SRC_N - 1;

  typedef logic [SRC_N-1:0]  src_vec_t;
  typedef logic [DATA_W-1:0] bus_word_t;

  // New mask from a write word: bit SEL_BIT picks set or clear.
  function automatic src_vec_t mask_apply(src_vec_t cur, bus_word_t d);
    src_vec_t sel;
    sel = d[SRC_N-1:0];
    if (d[SEL_BIT]) return cur | sel;
    return cur & ~sel;
  endfunction

  function automatic logic any_enabled(src_vec_t flags, src_vec_t mask);
    return |(flags & mask);
  endfunction

  function automatic bus_word_t pack_status(src_vec_t flags, logic summary);
    return {summary, {PAD_W{1'b0}}, flags};
  endfunction
endpackage

// File: rtl/irqu_flag_reg.sv
module irqu_flag_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_d_o,
  output logic [N-1:0] flags_q_o
);
  logic [N-1:0] flags_q;

  // Clear first, then merge new events so that none is dropped.
  always_comb flags_d_o = (clr_i ? '0 : flags_q) | evt_i;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d_o;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/irqu_mask_reg.sv
module irqu_mask_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  irqu_pkg::bus_word_t data_i,
  output irqu_pkg::src_vec_t  mask_d_o,
  output irqu_pkg::src_vec_t  mask_q_o
);
  irqu_pkg::src_vec_t mask_q;

  always_comb mask_d_o = wr_i ? irqu_pkg::mask_apply(mask_q, data_i) : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d_o;
  end

  assign mask_q_o = mask_q;
endmodule

// File: rtl/irqu_req_gen.sv
module irqu_req_gen (
  input  logic               clk,
  input  logic               rst_n,
  input  irqu_pkg::src_vec_t flags_d_i,
  input  irqu_pkg::src_vec_t mask_d_i,
  output logic               irq_n_o
);
  logic req_q;

  // Register the level from next-state values so it tracks the state edge for edge.
  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= irqu_pkg::any_enabled(flags_d_i, mask_d_i);
  end

  assign irq_n_o = ~req_q;
endmodule

// File: rtl/irq_flag_mask_unit.sv
module irq_flag_mask_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] evt_i,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  import irqu_pkg::*;

  src_vec_t flags_d, flags_q, mask_d, mask_q;
  logic     summary;
  logic     read_clear;

  assign read_clear = rd_stb;

  irqu_flag_reg #(.N(SRC_N)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .clr_i     (read_clear),
    .flags_d_o (flags_d),
    .flags_q_o (flags_q)
  );

  irqu_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_stb),
    .data_i   (wr_data),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  irqu_req_gen u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_d_i (flags_d),
    .mask_d_i  (mask_d),
    .irq_n_o   (irq_n)
  );

  assign summary = any_enabled(flags_q, mask_q);
  assign rd_data = pack_status(flags_q, summary);
endmodule

// File: rtl/irqu_chk.sv
module irqu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] evt_i,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq_n,
  input logic [4:0] flags_q,
  input logic [4:0] mask_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_n && flags_q == 5'd0 && mask_q == 5'd0));

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != 5'd0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data[7]) |=> ((mask_q & $past(wr_data[4:0])) == $past(wr_data[4:0])));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_data[7]) |=> ((mask_q & $past(wr_data[4:0])) == 5'd0));

  // R6
  irq_matches_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !rd_data[7]);

  // R8
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && evt_i == 5'd0) |=> (flags_q == 5'd0 && irq_n));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

bind irq_flag_mask_unit irqu_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_i   (evt_i),
  .rd_stb  (rd_stb),
  .wr_stb  (wr_stb),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq_n   (irq_n),
  .flags_q (flags_q),
  .mask_q  (mask_q)
);

// File: tb/tb_irq_flag_mask_unit.sv
`timescale 1ns/100ps
module tb_irq_flag_mask_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evt_i = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_flag_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
  );

  // Vector: evt[23:19] rd[18] wr[17] data[16:9] rd_data before edge[8:1] irq_n after[0]
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00001, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R2 masked event, R6 no irq
    {5'b00000, 1'b0, 1'b1, 8'h81, 8'h01, 1'b0}, // R3 R7 enable pending
    {5'b00000, 1'b0, 1'b0, 8'h00, 8'h81, 1'b0}, // R5 summary
    {5'b00000, 1'b1, 1'b0, 8'h00, 8'h81, 1'b1}, // R8 read clears
    {5'b00010, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R6 masked timer B
    {5'b10000, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1}, // R2 external edge
    {5'b00000, 1'b0, 1'b1, 8'h92, 8'h12, 1'b0}, // R3 set two bits
    {5'b00000, 1'b0, 1'b1, 8'h12, 8'h92, 1'b1}, // R4 clear two bits
    {5'b00100, 1'b1, 1'b0, 8'h00, 8'h12, 1'b1}, // R9 event during read, masked
    {5'b00000, 1'b0, 1'b1, 8'h9F, 8'h04, 1'b0}, // R3 set all
    {5'b01000, 1'b1, 1'b0, 8'h00, 8'h84, 1'b0}, // R9 event during read, enabled
    {5'b00000, 1'b1, 1'b0, 8'h00, 8'h88, 1'b1}, // R8
    {5'b00001, 1'b0, 1'b1, 8'h01, 8'h00, 1'b1}, // R4 clear with event
    {5'b00001, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}, // R10 repeat event
    {5'b00000, 1'b0, 1'b1, 8'h1F, 8'h01, 1'b1}, // R4 clear all
    {5'b00000, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1}  // R10 still pending
  };

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at falling edge, sample rd_data before the rising edge, irq_n after.
  task automatic step(logic [4:0] e, logic r, logic w, logic [7:0] d,
                      output logic [7:0] seen_rd, output logic seen_irq);
    @(negedge clk);
    evt_i = e; rd_stb = r; wr_stb = w; wr_data = d;
    #1 seen_rd = rd_data;
    @(posedge clk);
    #0.5;
    evt_i = '0; rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    seen_irq = irq_n;
  endtask

  initial begin
    logic [7:0] r8;
    logic       i1;
    repeat (3) @(posedge clk);
    #1;
    check8("R1", rd_data, 8'h00);
    check1("R1", irq_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][23:19], VEC[k][18], VEC[k][17], VEC[k][16:9], r8, i1);
      check8($sformatf("vec%0d", k), r8, VEC[k][8:1]);
      check1($sformatf("vec%0d", k), i1, VEC[k][0]);
    end

    // R2 each source sets its own bit; R2 pad bits read zero
    step(5'b00000, 1'b1, 1'b0, 8'h00, r8, i1);
    for (int s = 0; s < 5; s++) begin
      step(5'(1 << s), 1'b0, 1'b0, 8'h00, r8, i1);
      @(negedge clk); #1;
      check8("R2", rd_data, 8'((1 << (s + 1)) - 1));
    end

    // R1 reset in mid-operation
    step(5'b00000, 1'b0, 1'b1, 8'h9F, r8, i1);
    check1("R7", i1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #0.5;
    check1("R1", irq_n, 1'b1);
    check8("R1", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 mask cleared by reset: event alone must not request
    step(5'b00001, 1'b0, 1'b0, 8'h00, r8, i1);
    check1("R1", i1, 1'b1);
    @(negedge clk); #1;
    check8("R1", rd_data, 8'h01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule